// File: doc/BRIEF.md
# UART Register Front End

This block is the register side of a UART. It sits on a 16-bit register bus and holds four registers: control, status, transmit data and receive data. It decodes the control fields and drives them to the serializer and deserializer. It passes transmit bytes to the serializer with a one-cycle start strobe. It captures frames that the deserializer delivers. It keeps the two status flags, transmit ready and receive available, and raises one interrupt line from them.

Bus accesses complete in a single cycle. Read data is a combinational decode of the address and the current register contents. A write or a read side effect takes hold at the clock edge that ends the access. Bit serialization, frame deserialization and baud timing are handled by separate logic outside this block.

Top module: `uart_reg_front`

## Requirements
- R1: After reset every register reads 0 (control at offset 0x30, status at 0x31, receive data at 0x36), and irq_o, tx_start_o, tx_en_o and rx_en_o are low.
- R2: A write to control (offset 0x30) stores wdata bits 7:0, and bits 15:8 read back as 0. The fields are: bit 7 transmit enable (tx_en_o), bit 6 receive enable (rx_en_o), bit 5 nine-bit frames (frame9_o), bit 4 multiprocessor mode (multiproc_o), bits 3:2 ninth-bit mode, bit 1 transmit interrupt enable, bit 0 receive interrupt enable.
- R3: With nine-bit frames selected, tx_ninth_o follows the ninth-bit mode. Mode 0 gives constant 0 and mode 1 gives constant 1. Mode 2 gives odd parity, so the ninth bit makes the count of ones in the byte plus the ninth bit odd. Mode 3 gives even parity. With eight-bit frames, tx_ninth_o is 0.
- R4: A write to transmit data (offset 0x35) raises tx_start_o in the same cycle, with tx_byte_o equal to wdata bits 7:0. From the next cycle, status bit 1 (transmit ready) is set.
- R5: A control write that takes transmit enable from 0 to 1 sets status bit 1. A control write that leaves transmit enable at 1 does not set it.
- R6: tx_busy_i clears status bit 1 at the next edge. tx_done_i sets it. Any set event (tx_done_i, a transmit data write, or a transmit enable rising edge) wins over tx_busy_i in the same cycle.
- R7: While receive enable is 1, a rx_valid_i pulse stores rx_frame_i and sets status bit 0 (receive available). In eight-bit frame mode, bit 8 of the stored value is 0. While receive enable is 0, rx_valid_i has no effect.
- R8: A read of receive data (offset 0x36) returns the stored 9-bit value in bits 8:0 and clears status bit 0 at the next edge. If a frame arrives in the same cycle, the new frame is stored and bit 0 stays set.
- R9: A control write with bit 6 clear zeroes the receive data register and status bit 0, even when a frame arrives in the same cycle.
- R10: irq_o is high exactly when (control bit 1 and status bit 1) or (control bit 0 and status bit 0).
- R11: Status is read-only: writes to offset 0x31 change nothing. Reads of transmit data (0x35) and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | ADDR_W (8) | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| tx_start_o | output | 1 | Start strobe to serializer |
| tx_byte_o | output | 8 | Byte to serialize |
| tx_ninth_o | output | 1 | Ninth bit for the frame |
| tx_busy_i | input | 1 | Serializer is shifting |
| tx_done_i | input | 1 | Serializer finished a frame |
| rx_valid_i | input | 1 | Deserializer has a frame |
| rx_frame_i | input | 9 | Received frame, bit 8 is the ninth bit |
| tx_en_o | output | 1 | Transmit enable field |
| rx_en_o | output | 1 | Receive enable field |
| frame9_o | output | 1 | Nine-bit frame select |
| multiproc_o | output | 1 | Multiprocessor mode field |
| irq_o | output | 1 | Interrupt request |

## Verification
Each status flag can see a set event and a clear event in the same cycle, and the bench provokes both cases on purpose. For transmit ready, tx_busy_i is held high during a transmit data write. The following status read must still show bit 1. For receive available, a frame arrives during a read of receive data, and again during a control write that clears receive enable. In the first case the new frame must be kept with the flag set. In the second case both the data and the flag must be zero. A behavioural model decides every cycle's expected value, and directed reads after each collision confirm the result at the bus.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int unsigned OFS_CTRL = 'h30;
  localparam int unsigned OFS_STAT = 'h31;
  localparam int unsigned OFS_TXD  = 'h35;
  localparam int unsigned OFS_RXD  = 'h36;

  typedef enum logic [1:0] {
    NINTH_ZERO = 2'd0,
    NINTH_ONE  = 2'd1,
    NINTH_ODD  = 2'd2,
    NINTH_EVEN = 2'd3
  } ninth_mode_e;

  // field order is the bus bit order 7..0
  typedef struct packed {
    logic        tx_en;
    logic        rx_en;
    logic        frame9;
    logic        multiproc;
    ninth_mode_e ninth;
    logic        tx_ie;
    logic        rx_ie;
  } ctrl_t;

  typedef struct packed {
    logic ctrl_wr;
    logic tx_wr;
    logic rx_rd;
  } strobe_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_RXD
  } rsel_e;
endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
  import uart_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output strobe_t           strb_o,
  output rsel_e             rsel_o
);
  logic hit_ctrl, hit_stat, hit_txd, hit_rxd;

  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
  assign hit_txd  = (addr_i == ADDR_W'(OFS_TXD));
  assign hit_rxd  = (addr_i == ADDR_W'(OFS_RXD));

  // status write is decoded to nothing: register is read-only
  assign strb_o.ctrl_wr = req_i & we_i & hit_ctrl;
  assign strb_o.tx_wr   = req_i & we_i & hit_txd;
  assign strb_o.rx_rd   = req_i & ~we_i & hit_rxd;

  always_comb begin
    rsel_o = SEL_NONE;
    if (hit_ctrl)      rsel_o = SEL_CTRL;
    else if (hit_stat) rsel_o = SEL_STAT;
    else if (hit_rxd)  rsel_o = SEL_RXD;
  end
endmodule

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl
  import uart_fe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wbits_i,
  output ctrl_t      ctrl_o,
  output logic       tx_rise_o,
  output logic       rx_flush_o
);
  ctrl_t ctrl_q, ctrl_d;

  assign ctrl_d = ctrl_t'(wbits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o     = ctrl_q;
  assign tx_rise_o  = wr_i & ctrl_d.tx_en & ~ctrl_q.tx_en;
  assign rx_flush_o = wr_i & ~ctrl_d.rx_en;
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic              tx_rise_i,
  input  logic              tx_busy_i,
  input  logic              tx_done_i,
  input  logic [CHAR_W-1:0] wbyte_i,
  input  logic              frame9_i,
  input  ninth_mode_e       ninth_i,
  output logic              tx_start_o,
  output logic [CHAR_W-1:0] tx_byte_o,
  output logic              tx_ninth_o,
  output logic              tx_ready_o
);
  logic ready_q, set_ev, par;

  assign set_ev = tx_wr_i | tx_rise_i | tx_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ready_q <= 1'b0;
    else if (set_ev)    ready_q <= 1'b1;
    else if (tx_busy_i) ready_q <= 1'b0;
  end

  assign par = ^wbyte_i;

  always_comb begin
    tx_ninth_o = 1'b0;
    if (frame9_i) begin
      unique case (ninth_i)
        NINTH_ZERO: tx_ninth_o = 1'b0;
        NINTH_ONE:  tx_ninth_o = 1'b1;
        NINTH_ODD:  tx_ninth_o = ~par;
        NINTH_EVEN: tx_ninth_o = par;
        default:    tx_ninth_o = 1'b0;
      endcase
    end
  end

  assign tx_start_o = tx_wr_i;
  assign tx_byte_o  = wbyte_i;
  assign tx_ready_o = ready_q;
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx #(
  parameter int unsigned CHAR_W = 8,
  localparam int unsigned RX_W = CHAR_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_en_i,
  input  logic            frame9_i,
  input  logic            flush_i,
  input  logic            rd_i,
  input  logic            rx_valid_i,
  input  logic [RX_W-1:0] rx_frame_i,
  output logic [RX_W-1:0] rx_data_o,
  output logic            rx_avail_o
);
  logic [RX_W-1:0] data_q, frame_m;
  logic            avail_q, take;

  assign take    = rx_valid_i & rx_en_i;
  assign frame_m = {rx_frame_i[RX_W-1] & frame9_i, rx_frame_i[CHAR_W-1:0]};

  // flush beats arrival, arrival beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      avail_q <= 1'b0;
    end else if (flush_i) begin
      data_q  <= '0;
      avail_q <= 1'b0;
    end else if (take) begin
      data_q  <= frame_m;
      avail_q <= 1'b1;
    end else if (rd_i) begin
      avail_q <= 1'b0;
    end
  end

  assign rx_data_o  = data_q;
  assign rx_avail_o = avail_q;
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8,
  localparam int unsigned RX_W = CHAR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tx_start_o,
  output logic [CHAR_W-1:0] tx_byte_o,
  output logic              tx_ninth_o,
  input  logic              tx_busy_i,
  input  logic              tx_done_i,
  input  logic              rx_valid_i,
  input  logic [RX_W-1:0]   rx_frame_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              frame9_o,
  output logic              multiproc_o,
  output logic              irq_o
);
  strobe_t         strb;
  rsel_e           rsel;
  ctrl_t           ctrl;
  logic            tx_rise, rx_flush, tx_ready, rx_avail;
  logic [RX_W-1:0] rx_data;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CHAR_W];

  uart_fe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .strb_o (strb),
    .rsel_o (rsel)
  );

  uart_fe_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (strb.ctrl_wr),
    .wbits_i    (wdata_i[7:0]),
    .ctrl_o     (ctrl),
    .tx_rise_o  (tx_rise),
    .rx_flush_o (rx_flush)
  );

  uart_fe_tx #(.CHAR_W(CHAR_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_wr_i    (strb.tx_wr),
    .tx_rise_i  (tx_rise),
    .tx_busy_i  (tx_busy_i),
    .tx_done_i  (tx_done_i),
    .wbyte_i    (wdata_i[CHAR_W-1:0]),
    .frame9_i   (ctrl.frame9),
    .ninth_i    (ctrl.ninth),
    .tx_start_o (tx_start_o),
    .tx_byte_o  (tx_byte_o),
    .tx_ninth_o (tx_ninth_o),
    .tx_ready_o (tx_ready)
  );

  uart_fe_rx #(.CHAR_W(CHAR_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_en_i    (ctrl.rx_en),
    .frame9_i   (ctrl.frame9),
    .flush_i    (rx_flush),
    .rd_i       (strb.rx_rd),
    .rx_valid_i (rx_valid_i),
    .rx_frame_i (rx_frame_i),
    .rx_data_o  (rx_data),
    .rx_avail_o (rx_avail)
  );

  always_comb begin
    rdata_o = '0;
    unique case (rsel)
      SEL_CTRL: rdata_o = DATA_W'(ctrl);
      SEL_STAT: rdata_o = DATA_W'({tx_ready, rx_avail});
      SEL_RXD:  rdata_o = DATA_W'(rx_data);
      default:  rdata_o = '0;
    endcase
  end

  assign tx_en_o     = ctrl.tx_en;
  assign rx_en_o     = ctrl.rx_en;
  assign frame9_o    = ctrl.frame9;
  assign multiproc_o = ctrl.multiproc;
  assign irq_o       = (ctrl.tx_ie & tx_ready) | (ctrl.rx_ie & rx_avail);
endmodule

// File: rtl/uart_fe_checker.sv
module uart_fe_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RX_W   = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              tx_busy_i,
  input logic              tx_done_i,
  input logic              rx_valid_i,
  input logic              tx_en_o,
  input logic              rx_en_o,
  input logic              irq_o,
  input logic              tx_ready,
  input logic              rx_avail,
  input logic [RX_W-1:0]   rx_data
);
  logic ctrl_wr, tx_wr, rx_rd, rise;

  assign ctrl_wr = req_i & we_i & (addr_i == ADDR_W'('h30));
  assign tx_wr   = req_i & we_i & (addr_i == ADDR_W'('h35));
  assign rx_rd   = req_i & ~we_i & (addr_i == ADDR_W'('h36));
  assign rise    = ctrl_wr & wdata_i[7] & ~tx_en_o;

  p_tx_write_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr |=> tx_ready);

  p_tx_en_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> tx_ready);

  p_busy_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_i && !tx_done_i && !tx_wr && !rise) |=> !tx_ready);

  p_rx_off_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_o && !ctrl_wr) |=> $stable(rx_data));

  p_rx_read_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && !(rx_valid_i && rx_en_o) && !ctrl_wr) |=> !rx_avail);

  p_rx_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[6]) |=> (!rx_avail && rx_data == '0));

  p_irq_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (tx_ready || rx_avail));
endmodule

bind uart_reg_front uart_fe_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RX_W(RX_W)
) u_fe_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .tx_busy_i  (tx_busy_i),
  .tx_done_i  (tx_done_i),
  .rx_valid_i (rx_valid_i),
  .tx_en_o    (tx_en_o),
  .rx_en_o    (rx_en_o),
  .irq_o      (irq_o),
  .tx_ready   (tx_ready),
  .rx_avail   (rx_avail),
  .rx_data    (rx_data)
);

// File: tb/uart_reg_front_test.sv
module uart_reg_front_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        tx_start_o, tx_ninth_o;
  logic [7:0]  tx_byte_o;
  logic        tx_busy_i = 1'b0, tx_done_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [8:0]  rx_frame_i = '0;
  logic        tx_en_o, rx_en_o, frame9_o, multiproc_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_ctrl = '0;
  logic       m_ready = 0, m_avail = 0;
  logic [8:0] m_rxd = '0;

  uart_reg_front uut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .tx_start_o, .tx_byte_o, .tx_ninth_o, .tx_busy_i, .tx_done_i,
    .rx_valid_i, .rx_frame_i, .tx_en_o, .rx_en_o, .frame9_o,
    .multiproc_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_ninth(input logic [7:0] c, input logic [7:0] b);
    if (!c[5]) return 1'b0;
    case (c[3:2])
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return ~(^b);
      default: return ^b;
    endcase
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [7:0] a);
    case (a)
      8'h30: return {8'h00, m_ctrl};
      8'h31: return {14'h0, m_ready, m_avail};
      8'h36: return {7'h0, m_rxd};
      default: return 16'h0;
    endcase
  endfunction

  // model update at the edge, compare a quarter period later
  initial begin
    forever begin
      @(posedge clk_i);
      if (rst_ni) begin
        automatic bit wr  = req_i && we_i;
        automatic bit cw  = wr && addr_i == 8'h30;
        automatic bit tw  = wr && addr_i == 8'h35;
        automatic bit rr  = req_i && !we_i && addr_i == 8'h36;
        automatic bit ris = cw && wdata_i[7] && !m_ctrl[7];
        if (tw || ris || tx_done_i) m_ready = 1;
        else if (tx_busy_i)         m_ready = 0;
        if (cw && !wdata_i[6]) begin
          m_avail = 0; m_rxd = '0;
        end else if (rx_valid_i && m_ctrl[6]) begin
          m_avail = 1;
          m_rxd = {rx_frame_i[8] & m_ctrl[5], rx_frame_i[7:0]};
        end else if (rr) m_avail = 0;
        if (cw) m_ctrl = wdata_i[7:0];
      end
      #(CLK_PERIOD/4);
      if (rst_ni) begin
        automatic bit tw2 = req_i && we_i && addr_i == 8'h35;
        case (addr_i)
          8'h30: chk("R2 rdata", rdata_o, exp_rdata(addr_i));
          8'h31: chk("R6 rdata", rdata_o, exp_rdata(addr_i));
          8'h36: chk("R8 rdata", rdata_o, exp_rdata(addr_i));
          default: chk("R11 rdata", rdata_o, exp_rdata(addr_i));
        endcase
        chk("R4 tx_start", tx_start_o, tw2);
        if (tw2) chk("R4 tx_byte", tx_byte_o, wdata_i[7:0]);
        chk("R3 tx_ninth", tx_ninth_o, exp_ninth(m_ctrl, wdata_i[7:0]));
        chk("R2 fields", {tx_en_o, rx_en_o, frame9_o, multiproc_o}, m_ctrl[7:4]);
        chk("R10 irq", irq_o, (m_ctrl[1] & m_ready) | (m_ctrl[0] & m_avail));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0; addr_i = 8'h00;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    #1 chk(tag, rdata_o, exp);
    @(negedge clk_i); req_i = 0; addr_i = 8'h00;
  endtask

  task automatic tx_send(input logic [7:0] b, input logic ninth, input logic busy);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = 8'h35;
    wdata_i = {8'h7E, b}; tx_busy_i = busy;
    #1;
    chk("R4 start", tx_start_o, 1'b1);
    chk("R4 byte", tx_byte_o, b);
    chk("R3 ninth", tx_ninth_o, ninth);
    @(negedge clk_i); req_i = 0; we_i = 0; addr_i = 8'h00; tx_busy_i = 0;
  endtask

  task automatic pulse(input bit busy, input bit dn);
    @(negedge clk_i); tx_busy_i = busy; tx_done_i = dn;
    @(negedge clk_i); tx_busy_i = 0; tx_done_i = 0;
  endtask

  task automatic rx_in(input logic [8:0] f);
    @(negedge clk_i); rx_valid_i = 1; rx_frame_i = f;
    @(negedge clk_i); rx_valid_i = 0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd_check(8'h30, 16'h0000, "R1 ctrl");
    rd_check(8'h31, 16'h0000, "R1 status");
    rd_check(8'h36, 16'h0000, "R1 rxdata");
    chk("R1 outputs", {irq_o, tx_start_o, tx_en_o, rx_en_o}, 4'b0);

    // R5 rising tx enable, R2 readback
    wr(8'h30, 16'h0080);
    rd_check(8'h31, 16'h0002, "R5 rise sets ready");
    wr(8'h30, 16'hFF80);
    rd_check(8'h30, 16'h0080, "R2 upper bits dropped");

    // R6 busy clears, R5 no rise keeps it clear, R10
    pulse(1, 0);
    rd_check(8'h31, 16'h0000, "R6 busy clears");
    wr(8'h30, 16'h0082);
    rd_check(8'h31, 16'h0000, "R5 no rise");
    chk("R10 irq off", irq_o, 1'b0);
    pulse(0, 1);
    rd_check(8'h31, 16'h0002, "R6 done sets");
    chk("R10 irq tx", irq_o, 1'b1);

    // R3 ninth modes with 9-bit frames, byte A5 has four ones
    for (int m = 0; m < 4; m++) begin
      automatic logic [3:0] nin = 4'b0110;
      wr(8'h30, 16'h00A2 | 16'(m << 2));
      pulse(1, 0);
      tx_send(8'hA5, nin[m], 0);
      rd_check(8'h31, 16'h0002, "R4 write sets ready");
    end
    wr(8'h30, 16'h00AE);
    tx_send(8'hA7, 1'b1, 0); // five ones, even mode
    wr(8'h30, 16'h0086);
    tx_send(8'hA7, 1'b0, 0); // R3 eight-bit frames force 0
    wr(8'h30, 16'h0092);
    chk("R2 multiproc", multiproc_o, 1'b1);

    // R6 collision: busy and write in one cycle
    pulse(1, 0);
    tx_send(8'h3C, 1'b0, 1);
    rd_check(8'h31, 16'h0002, "R6 set wins over busy");

    // R7 receive disabled ignores frames
    wr(8'h30, 16'h0082);
    rx_in(9'h155);
    rd_check(8'h31, 16'h0002, "R7 ignored status");
    rd_check(8'h36, 16'h0000, "R7 ignored data");

    // R7/R8 capture and read-clear
    wr(8'h30, 16'h00E3);
    rx_in(9'h155);
    rd_check(8'h31, 16'h0003, "R7 avail set");
    rd_check(8'h36, 16'h0155, "R8 data");
    rd_check(8'h31, 16'h0002, "R8 read clears");

    // R7 eight-bit frames mask bit 8
    wr(8'h30, 16'h00C3);
    rx_in(9'h1C3);
    rd_check(8'h36, 16'h00C3, "R7 bit8 masked");

    // R8 collision: arrival during read
    rx_in(9'h011);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = 8'h36;
    rx_valid_i = 1; rx_frame_i = 9'h022;
    #1 chk("R8 old data read", rdata_o, 16'h0011);
    @(negedge clk_i); req_i = 0; addr_i = 8'h00; rx_valid_i = 0;
    rd_check(8'h31, 16'h0003, "R8 arrival wins");
    rd_check(8'h36, 16'h0022, "R8 new data kept");

    // R9 collision: flush during arrival
    rx_in(9'h033);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = 8'h30; wdata_i = 16'h0083;
    rx_valid_i = 1; rx_frame_i = 9'h044;
    @(negedge clk_i); req_i = 0; we_i = 0; addr_i = 8'h00; rx_valid_i = 0;
    rd_check(8'h31, 16'h0002, "R9 flush status");
    rd_check(8'h36, 16'h0000, "R9 flush data");

    // R11 read-only status and empty offsets
    wr(8'h31, 16'hFFFF);
    rd_check(8'h31, 16'h0002, "R11 status write ignored");
    rd_check(8'h35, 16'h0000, "R11 txd reads 0");
    rd_check(8'h3F, 16'h0000, "R11 unmapped");

    // R10 receive-only interrupt
    wr(8'h30, 16'h0041);
    rx_in(9'h0AA);
    chk("R10 irq rx", irq_o, 1'b1);
    rd_check(8'h36, 16'h00AA, "R8 data");
    chk("R10 irq cleared", irq_o, 1'b0);

    repeat (2) @(negedge clk_i);
    done = 1;
    finish_up();
  end
endmodule